// File: doc/BRIEF.md
# Calendar Time Counter With Hour Modes

This block keeps wall-clock time and calendar date in BCD. It counts seconds, minutes, hours, day of week, date, month, year and century, and advances once for each cycle in which the one-pulse-per-second tick input is high. Hours run in 24-hour form or in 12-hour form with an afternoon bit. A mode bit selects the form, and software can change that bit at any time. Month lengths follow the calendar. A two-digit year divisible by four gives February a 29th day. When the year rolls past 99, a separate century field moves from 19 to 20.

Software loads and reads each field through a synchronous write port and a combinational read port that share one 3-bit address map. The counter is frozen after reset and after a pulse on the total-power-loss input. In both cases every field holds its default value, and counting resumes only after software writes at least one byte.

Top module: `rtc_cal_counter`

## Requirements
- R1: After reset the fields read seconds 00, minutes 00, hour byte 0x12 (12-hour form, AM, hour 12), day of week 0, date 01, month 01, year 00 and century 20.
- R2: Seconds and minutes count in BCD from 00 to 59. A tick at second 59 gives second 00 and advances the minute. Minute 59 wrapping advances the hour.
- R3: With hour-byte bit 7 (24-hour mode) at 1, hours count 00 to 23 in BCD in bits 5:0. Going from 23 to 00 advances the date and the day of week. In this mode the PM bit changes only by a write.
- R4: With bit 7 at 0, hours count 12, 01, 02 up to 11. Bit 6 (PM) toggles on the step from 11 to 12. The date advances only on the step from 11 PM to 12 AM.
- R5: Day of week counts 0 to 6 and wraps to 0 on each date advance. A write of a value above 6 to it is ignored.
- R6: Date counts from 01. April, June, September and November end at 30. January, March, May, July, August, October and December end at 31. Month counts 01 to 12, and December 31 rolls to January 01.
- R7: February ends at 29 when the binary value of the BCD year is divisible by 4 (year 00 included), and at 28 otherwise.
- R8: Year counts 00 to 99. The step from 99 to 00 sets the century to 20, whether it held 19 or 20. A century write of any value other than 0x19 or 0x20 is ignored.
- R9: In the cycle after total-power-loss is high, and also after reset, every field holds its R1 default and ticks have no effect. The first write of any byte ends this frozen state.
- R10: A write and a tick in the same cycle apply the write only. The tick is dropped, so no other field moves.
- R11: Address map (read and write): 0 seconds, 1 minutes, 2 hour byte {24-hour mode, PM, hour[5:0]}, 3 day of week (bits 2:0), 4 date, 5 month, 6 year, 7 century. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse once per second |
| pwr_lost_i | input | 1 | Total-power-loss recovery flag; restores defaults and freezes counting |
| wr_en_i | input | 1 | Field write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 8 | Read data for rd_addr_i |

## Verification
Some rules are checked on every cycle by the assertions. Day of week stays in range and the century stays legal. A write wins over a tick and releases the frozen state. A power-loss pulse restores defaults, and all fields stay stable while the counter is frozen. Every live tick moves the seconds, and the PM bit is held in 24-hour mode. The bench scenarios cover the rest: the exact carry chains across month lengths, leap and non-leap Februaries, the 12-hour sequence with its PM toggle and date step, and the century rollover. These need specific preloaded dates and a comparison of every field after the tick.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned HOUR_W = 6;
  localparam int unsigned DOW_W  = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_SEC, A_MIN, A_HOUR, A_DOW, A_DATE, A_MONTH, A_YEAR, A_CENT
  } reg_addr_e;

  typedef struct packed {
    logic [BYTE_W-1:0] sec;
    logic [BYTE_W-1:0] min;
    logic [HOUR_W-1:0] hr;
    logic              mode24;
    logic              pm;
    logic [DOW_W-1:0]  dow;
    logic [BYTE_W-1:0] date;
    logic [BYTE_W-1:0] mon;
    logic [BYTE_W-1:0] yr;
    logic [BYTE_W-1:0] cent;
  } cal_t;

  function automatic logic [BYTE_W-1:0] bcd_inc(input logic [BYTE_W-1:0] v);
    logic [3:0] tens;
    tens = v[7:4] + 4'd1;
    if (v[3:0] >= 4'd9) return {tens, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [6:0] bcd_to_bin(input logic [BYTE_W-1:0] v);
    return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
  endfunction
endpackage

// File: rtl/rtc_bcd_step.sv
module rtc_bcd_step
  import rtc_cal_pkg::*;
(
  input  logic [BYTE_W-1:0] cur_i,
  input  logic [BYTE_W-1:0] lo_i,
  input  logic [BYTE_W-1:0] hi_i,
  output logic [BYTE_W-1:0] nxt_o,
  output logic              wrap_o
);
  // >= so an out-of-range software value still wraps
  assign wrap_o = (cur_i >= hi_i);
  assign nxt_o  = wrap_o ? lo_i : bcd_inc(cur_i);
endmodule

// File: rtl/rtc_hour_step.sv
module rtc_hour_step
  import rtc_cal_pkg::*;
(
  input  logic [HOUR_W-1:0] hr_i,
  input  logic              mode24_i,
  input  logic              pm_i,
  output logic [HOUR_W-1:0] hr_o,
  output logic              pm_o,
  output logic              day_o
);
  logic [BYTE_W-1:0] inc;
  assign inc = bcd_inc({2'b00, hr_i});

  always_comb begin
    hr_o  = inc[HOUR_W-1:0];
    pm_o  = pm_i;
    day_o = 1'b0;
    if (mode24_i) begin
      if (hr_i >= 6'h23) begin
        hr_o  = '0;
        day_o = 1'b1;
      end
    end else if (hr_i == 6'h11) begin
      hr_o  = 6'h12;
      pm_o  = ~pm_i;
      day_o = pm_i;
    end else if (hr_i >= 6'h12) begin
      hr_o = 6'h01;
    end
  end
endmodule

// File: rtl/rtc_month_len.sv
module rtc_month_len
  import rtc_cal_pkg::*;
(
  input  logic [BYTE_W-1:0] mon_i,
  input  logic [BYTE_W-1:0] yr_i,
  output logic [BYTE_W-1:0] last_o
);
  logic [6:0] yr_bin;
  logic       leap;
  assign yr_bin = bcd_to_bin(yr_i);
  assign leap   = (yr_bin[1:0] == 2'b00);

  always_comb begin
    unique case (mon_i)
      8'h02:                      last_o = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_o = 8'h30;
      default:                    last_o = 8'h31;
    endcase
  end
endmodule

// File: rtl/rtc_cal_counter.sv
module rtc_cal_counter
  import rtc_cal_pkg::*;
#(
  parameter logic [BYTE_W-1:0] CENT_DEF = 8'h20,
  parameter logic [BYTE_W-1:0] CENT_ALT = 8'h19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              pwr_lost_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [BYTE_W-1:0] rd_data_o
);
  localparam cal_t CAL_DEF = '{
    sec: 8'h00, min: 8'h00, hr: 6'h12, mode24: 1'b0, pm: 1'b0,
    dow: '0, date: 8'h01, mon: 8'h01, yr: 8'h00, cent: CENT_DEF};
  localparam logic [BYTE_W-1:0] DOW_MAX = 8'd6;

  cal_t st_q;
  logic halted_q;

  logic [BYTE_W-1:0] sec_n, min_n, date_n, mon_n, yr_n, last_day;
  logic              sec_w, min_w, date_w, mon_w, yr_w;
  logic [HOUR_W-1:0] hr_n;
  logic              pm_n, day_c;
  logic              en_sec, en_min, en_hr, en_day, en_mon, en_yr;

  rtc_bcd_step u_sec  (.cur_i(st_q.sec),  .lo_i(8'h00), .hi_i(8'h59),
                       .nxt_o(sec_n),  .wrap_o(sec_w));
  rtc_bcd_step u_min  (.cur_i(st_q.min),  .lo_i(8'h00), .hi_i(8'h59),
                       .nxt_o(min_n),  .wrap_o(min_w));
  rtc_hour_step u_hr  (.hr_i(st_q.hr), .mode24_i(st_q.mode24), .pm_i(st_q.pm),
                       .hr_o(hr_n), .pm_o(pm_n), .day_o(day_c));
  rtc_month_len u_len (.mon_i(st_q.mon), .yr_i(st_q.yr), .last_o(last_day));
  rtc_bcd_step u_date (.cur_i(st_q.date), .lo_i(8'h01), .hi_i(last_day),
                       .nxt_o(date_n), .wrap_o(date_w));
  rtc_bcd_step u_mon  (.cur_i(st_q.mon),  .lo_i(8'h01), .hi_i(8'h12),
                       .nxt_o(mon_n),  .wrap_o(mon_w));
  rtc_bcd_step u_yr   (.cur_i(st_q.yr),   .lo_i(8'h00), .hi_i(8'h99),
                       .nxt_o(yr_n),   .wrap_o(yr_w));

  // carry chain
  assign en_sec = tick_i & ~halted_q;
  assign en_min = en_sec & sec_w;
  assign en_hr  = en_min & min_w;
  assign en_day = en_hr  & day_c;
  assign en_mon = en_day & date_w;
  assign en_yr  = en_mon & mon_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= CAL_DEF;
      halted_q <= 1'b1;
    end else if (pwr_lost_i) begin
      st_q     <= CAL_DEF;
      halted_q <= 1'b1;
    end else if (wr_en_i) begin
      halted_q <= 1'b0;
      unique case (reg_addr_e'(wr_addr_i))
        A_SEC:   st_q.sec  <= wr_data_i;
        A_MIN:   st_q.min  <= wr_data_i;
        A_HOUR: begin
          st_q.mode24 <= wr_data_i[7];
          st_q.pm     <= wr_data_i[6];
          st_q.hr     <= wr_data_i[HOUR_W-1:0];
        end
        A_DOW:   if (wr_data_i <= DOW_MAX) st_q.dow <= wr_data_i[DOW_W-1:0];
        A_DATE:  st_q.date <= wr_data_i;
        A_MONTH: st_q.mon  <= wr_data_i;
        A_YEAR:  st_q.yr   <= wr_data_i;
        A_CENT:  if (wr_data_i == CENT_DEF || wr_data_i == CENT_ALT)
                   st_q.cent <= wr_data_i;
        default: ;
      endcase
    end else begin
      if (en_sec) st_q.sec <= sec_n;
      if (en_min) st_q.min <= min_n;
      if (en_hr) begin
        st_q.hr <= hr_n;
        st_q.pm <= pm_n;
      end
      if (en_day) begin
        st_q.date <= date_n;
        st_q.dow  <= (st_q.dow >= DOW_W'(DOW_MAX)) ? '0 : st_q.dow + 1'b1;
      end
      if (en_mon) st_q.mon <= mon_n;
      if (en_yr) begin
        st_q.yr <= yr_n;
        if (yr_w) st_q.cent <= CENT_DEF;
      end
    end
  end

  always_comb begin
    unique case (reg_addr_e'(rd_addr_i))
      A_SEC:   rd_data_o = st_q.sec;
      A_MIN:   rd_data_o = st_q.min;
      A_HOUR:  rd_data_o = {st_q.mode24, st_q.pm, st_q.hr};
      A_DOW:   rd_data_o = {{(BYTE_W-DOW_W){1'b0}}, st_q.dow};
      A_DATE:  rd_data_o = st_q.date;
      A_MONTH: rd_data_o = st_q.mon;
      A_YEAR:  rd_data_o = st_q.yr;
      default: rd_data_o = st_q.cent;
    endcase
  end
endmodule

// File: rtl/rtc_cal_chk.sv
module rtc_cal_chk
  import rtc_cal_pkg::*;
#(
  parameter logic [BYTE_W-1:0] CENT_DEF = 8'h20,
  parameter logic [BYTE_W-1:0] CENT_ALT = 8'h19
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              pwr_lost_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [BYTE_W-1:0] wr_data_i,
  input logic              halted,
  input cal_t              st
);
  AST_LOSS_DEFAULTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_lost_i |=> halted && st.sec == 8'h00 && st.hr == 6'h12 && !st.mode24
                   && st.dow == '0 && st.date == 8'h01 && st.cent == CENT_DEF); // R9
  AST_FROZEN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted && !wr_en_i && !pwr_lost_i |=> $stable(st)); // R9
  AST_WRITE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !pwr_lost_i |=> !halted); // R9
  AST_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !pwr_lost_i && wr_addr_i == ADDR_W'(A_SEC)
    |=> st.sec == $past(wr_data_i) && $stable(st.min)); // R10
  AST_DOW_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st.dow <= 3'd6); // R5
  AST_CENT_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st.cent == CENT_DEF || st.cent == CENT_ALT); // R8
  AST_SEC_MOVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !halted && !wr_en_i && !pwr_lost_i |=> st.sec != $past(st.sec)); // R2
  AST_PM_HOLD_24H: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st.mode24 && !wr_en_i && !pwr_lost_i |=> $stable(st.pm)); // R3
endmodule

bind rtc_cal_counter rtc_cal_chk #(.CENT_DEF(CENT_DEF), .CENT_ALT(CENT_ALT)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .pwr_lost_i(pwr_lost_i),
  .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
  .halted(halted_q), .st(st_q));

// File: tb/rtc_cal_counter_bench.sv
`timescale 1ns/1ps
module rtc_cal_counter_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, pwr_lost = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  int         n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  rtc_cal_counter u_rtc_cal_counter (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .pwr_lost_i(pwr_lost),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data));

  // hour,date,mon,yr,cent,dow written | same fields expected after one tick at mm:ss 59:59
  localparam int NV = 14;
  localparam logic [95:0] VEC [NV] = '{
    96'hA3_28_02_23_20_06_80_01_03_23_20_00,
    96'hA3_28_02_24_20_03_80_29_02_24_20_04,
    96'hA3_29_02_24_20_01_80_01_03_24_20_02,
    96'h90_15_07_05_20_02_91_15_07_05_20_02,
    96'h11_15_07_05_20_02_52_15_07_05_20_02,
    96'h51_30_04_10_20_05_12_01_05_10_20_06,
    96'h52_09_09_09_20_00_41_09_09_09_20_00,
    96'h12_09_09_09_20_00_01_09_09_09_20_00,
    96'hA3_31_12_99_19_04_80_01_01_00_20_05,
    96'hA3_31_12_99_20_04_80_01_01_00_20_05,
    96'hA3_30_06_11_20_06_80_01_07_11_20_00,
    96'hA3_28_02_00_20_01_80_29_02_00_20_02,
    96'hA3_28_02_01_20_01_80_01_03_01_20_02,
    96'hA3_31_01_05_20_00_80_01_02_05_20_01
  };

  task automatic chk(input string req, input string what, input logic [7:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic rchk(input string req, input string what, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    chk(req, what, d, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [95:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 R11 defaults
    rchk("R1", "sec", 3'd0, 8'h00);
    rchk("R1", "min", 3'd1, 8'h00);
    rchk("R1", "hour", 3'd2, 8'h12);
    rchk("R1", "dow", 3'd3, 8'h00);
    rchk("R1", "date", 3'd4, 8'h01);
    rchk("R11", "month", 3'd5, 8'h01);
    rchk("R11", "year", 3'd6, 8'h00);
    rchk("R11", "cent", 3'd7, 8'h20);
    // R9 frozen after reset
    do_tick();
    rchk("R9", "sec frozen after reset", 3'd0, 8'h00);
    wr(3'd1, 8'h10);
    do_tick();
    rchk("R9", "sec runs after write", 3'd0, 8'h01);

    // table walk
    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      wr(3'd0, 8'h59); wr(3'd1, 8'h59);
      wr(3'd2, v[95:88]); wr(3'd4, v[87:80]); wr(3'd5, v[79:72]);
      wr(3'd6, v[71:64]); wr(3'd7, v[63:56]); wr(3'd3, v[55:48]);
      do_tick();
      rchk("R2", "sec", 3'd0, 8'h00);
      rchk("R2", "min", 3'd1, 8'h00);
      rchk("R3 R4", "hour", 3'd2, v[47:40]);
      rchk("R6 R7", "date", 3'd4, v[39:32]);
      rchk("R6", "month", 3'd5, v[31:24]);
      rchk("R8", "year", 3'd6, v[23:16]);
      rchk("R8", "cent", 3'd7, v[15:8]);
      rchk("R5", "dow", 3'd3, v[7:0]);
    end

    // R2 second wrap without minute overflow
    wr(3'd1, 8'h07); wr(3'd0, 8'h58);
    do_tick();
    rchk("R2", "sec 59", 3'd0, 8'h59);
    rchk("R2", "min held", 3'd1, 8'h07);
    do_tick();
    rchk("R2", "sec wrap", 3'd0, 8'h00);
    rchk("R2", "min carry", 3'd1, 8'h08);

    // R10 write beats tick
    wr(3'd0, 8'h59); wr(3'd1, 8'h10);
    @(negedge clk); wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h30; tick = 1'b1;
    @(negedge clk); wr_en = 1'b0; tick = 1'b0;
    rchk("R10", "sec write wins", 3'd0, 8'h30);
    rchk("R10", "min not carried", 3'd1, 8'h10);

    // R5 illegal dow ignored; R8 illegal century ignored
    wr(3'd3, 8'h03); wr(3'd3, 8'h07);
    rchk("R5", "dow write 7 ignored", 3'd3, 8'h03);
    wr(3'd7, 8'h19); wr(3'd7, 8'h21);
    rchk("R8", "cent write 21 ignored", 3'd7, 8'h19);

    // R3 24h non-carry step keeps pm
    wr(3'd2, 8'hC5);
    wr(3'd1, 8'h59); wr(3'd0, 8'h59);
    do_tick();
    rchk("R3", "24h pm held", 3'd2, 8'hC6);

    // R9 power loss
    wr(3'd4, 8'h17); wr(3'd0, 8'h22);
    @(negedge clk); pwr_lost = 1'b1;
    @(negedge clk); pwr_lost = 1'b0;
    rchk("R9", "sec default", 3'd0, 8'h00);
    rchk("R9", "hour default", 3'd2, 8'h12);
    rchk("R9", "date default", 3'd4, 8'h01);
    rchk("R9", "cent default", 3'd7, 8'h20);
    do_tick(); do_tick();
    rchk("R9", "frozen after loss", 3'd0, 8'h00);
    wr(3'd6, 8'h05);
    do_tick();
    rchk("R9", "runs after write", 3'd0, 8'h01);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule